// File: doc/BRIEF.md
# Grouped-Word Slice Count Encoder

This block computes check information for a group of four 32-bit memory words at once, instead of protecting each word on its own. Every word is cut into eight 4-bit symbols. For each word, the bits that sit at the same position inside every symbol form a slice of eight bits, and the block counts the ones in each of the four slices. For each of the 32 bit columns, it counts the ones down the four words. It also reduces every count to a single parity bit.

The block has no clock and no state. The data path of a memory writes the four words into a data array and writes the counts and parity bits into a side array at the same time. A later checking stage recomputes the same values from the stored words and compares them with the stored ones. The parity redundancy for one group is 48 bits: 16 from the slices and 32 from the columns.

Top module: `grp_count_enc`

## Requirements
- R1: Word r occupies bits 32r+31..32r of `data_i`. Slice m of word r (m = 0..3) is made of word bits m, m+4, m+8, ..., m+28, which is bit m of each of the eight 4-bit symbols.
- R2: `row_cnt_o` field 4r+m, 4 bits wide at bit offset 4*(4r+m), holds the number of ones in slice m of word r, with a range of 0 to 8.
- R3: `col_cnt_o` field j, 3 bits wide at bit offset 3j, holds the number of ones in bit j across the four words, with a range of 0 to 4.
- R4: `row_par_o` bit 4r+m is the XOR of slice m of word r, which is the least significant bit of the matching slice count.
- R5: `col_par_o` bit j is the XOR of bit j across the four words, which is the least significant bit of the matching column count.
- R6: When all data bits are zero, every count and every parity output is zero.
- R7: When all data bits are one, every slice count is 8, every column count is 4, and every parity bit is zero.
- R8: The outputs depend only on the present input, with no register. A change on `data_i` shows on the outputs in the same time step, without any clock edge.
- R9: The sum of all sixteen slice counts equals the sum of all thirty-two column counts, and both equal the number of ones in the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 128 | Four data words; word r at bits 32r+31..32r |
| row_cnt_o | output | 64 | Slice ones-counts, 4-bit field 4r+m |
| row_par_o | output | 16 | Slice parity bits, bit 4r+m |
| col_cnt_o | output | 96 | Column ones-counts, 3-bit field j |
| col_par_o | output | 32 | Column parity bits, bit j |

## Verification
The hardest cases to reach are the ones at the top of each counter's range. A slice count of 8 needs all eight bits of one slice set in one word, and a column count of 4 needs the same bit set in every word. Random words almost never produce either. The stimulus table therefore holds saturating patterns (all ones, whole words set, one word with alternating nibbles), single-bit patterns at the lowest and highest data bits, and mixed-density groups, with the hand-counted total of ones stored beside each pattern. A further run of random groups is compared field by field against a popcount model in the bench.

// File: rtl/grp_count_enc.sv
module grp_count_enc #(
  parameter int ROWS   = 4,
  parameter int WORD_W = 32,
  parameter int SYM_W  = 4
) (
  input  logic [ROWS*WORD_W-1:0]                                   data_i,
  output logic [ROWS*SYM_W*$clog2(WORD_W/SYM_W+1)-1:0]             row_cnt_o,
  output logic [ROWS*SYM_W-1:0]                                    row_par_o,
  output logic [WORD_W*$clog2(ROWS+1)-1:0]                         col_cnt_o,
  output logic [WORD_W-1:0]                                        col_par_o
);
  localparam int SLICE_N = WORD_W / SYM_W;
  localparam int RC_W    = $clog2(SLICE_N + 1);
  localparam int CC_W    = $clog2(ROWS + 1);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar m = 0; m < SYM_W; m++) begin : g_slice
      logic [SLICE_N-1:0] slice;
      logic [RC_W-1:0]    cnt;
      for (genvar k = 0; k < SLICE_N; k++) begin : g_bit
        assign slice[k] = data_i[r*WORD_W + k*SYM_W + m];
      end
      always_comb begin
        cnt = '0;
        for (int k = 0; k < SLICE_N; k++) cnt = cnt + RC_W'(slice[k]);
      end
      assign row_cnt_o[(r*SYM_W+m)*RC_W +: RC_W] = cnt;
      assign row_par_o[r*SYM_W+m]                = ^slice;
    end
  end

  for (genvar j = 0; j < WORD_W; j++) begin : g_col
    logic [ROWS-1:0] col;
    logic [CC_W-1:0] cnt;
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign col[r] = data_i[r*WORD_W + j];
    end
    always_comb begin
      cnt = '0;
      for (int r = 0; r < ROWS; r++) cnt = cnt + CC_W'(col[r]);
    end
    assign col_cnt_o[j*CC_W +: CC_W] = cnt;
    assign col_par_o[j]              = ^col;
  end
endmodule

// File: rtl/grp_count_enc_chk.sv
module grp_count_enc_chk #(
  parameter int ROWS   = 4,
  parameter int WORD_W = 32,
  parameter int SYM_W  = 4
) (
  input logic [ROWS*WORD_W-1:0]                       data_i,
  input logic [ROWS*SYM_W*$clog2(WORD_W/SYM_W+1)-1:0] row_cnt_o,
  input logic [ROWS*SYM_W-1:0]                        row_par_o,
  input logic [WORD_W*$clog2(ROWS+1)-1:0]             col_cnt_o,
  input logic [WORD_W-1:0]                            col_par_o
);
  localparam int SLICE_N = WORD_W / SYM_W;
  localparam int RC_W    = $clog2(SLICE_N + 1);
  localparam int CC_W    = $clog2(ROWS + 1);

  int row_sum;
  int col_sum;

  always_comb begin
    row_sum = 0;
    col_sum = 0;
    for (int i = 0; i < ROWS*SYM_W; i++) begin
      row_sum = row_sum + int'(row_cnt_o[i*RC_W +: RC_W]);
      AST_ROW_CNT_RANGE: assert (int'(row_cnt_o[i*RC_W +: RC_W]) <= SLICE_N); // R2
      AST_ROW_PAR_LSB: assert (row_par_o[i] == row_cnt_o[i*RC_W]); // R4
    end
    for (int j = 0; j < WORD_W; j++) begin
      col_sum = col_sum + int'(col_cnt_o[j*CC_W +: CC_W]);
      AST_COL_CNT_RANGE: assert (int'(col_cnt_o[j*CC_W +: CC_W]) <= ROWS); // R3
      AST_COL_PAR_LSB: assert (col_par_o[j] == col_cnt_o[j*CC_W]); // R5
    end
    AST_TOTAL_MATCH: assert (row_sum == col_sum); // R9
    AST_ZERO_IN_ZERO_OUT: assert (data_i != '0 || (row_cnt_o == '0 && col_cnt_o == '0 && row_par_o == '0 && col_par_o == '0)); // R6
  end
endmodule

bind grp_count_enc grp_count_enc_chk #(.ROWS(ROWS), .WORD_W(WORD_W), .SYM_W(SYM_W)) u_chk (
  .data_i(data_i), .row_cnt_o(row_cnt_o), .row_par_o(row_par_o),
  .col_cnt_o(col_cnt_o), .col_par_o(col_par_o)
);

// File: tb/grp_count_enc_bench.sv
module grp_count_enc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4, WORD_W = 32, SYM_W = 4;
  localparam int SLICE_N = WORD_W / SYM_W;
  localparam int RC_W = 4, CC_W = 3;
  localparam int N_VEC = 8;
  localparam logic [127:0] STIM [N_VEC] = '{
    128'h0,
    {128{1'b1}},
    {4{32'hA5A5A5A5}},
    128'h1,
    {32'h80000000, 96'h0},
    {4{32'h12345678}},
    {32'h0000FFFF, 32'hF0F0F0F0, 32'h00000000, 32'hFFFFFFFF},
    {32'hAAAAAAAA, 32'h55555555, 32'h99999999, 32'h66666666}
  };
  localparam int ONES [N_VEC] = '{0, 128, 64, 1, 1, 52, 64, 64};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [127:0] data_i = '0;
  logic [63:0]  row_cnt_o;
  logic [15:0]  row_par_o;
  logic [95:0]  col_cnt_o;
  logic [31:0]  col_par_o;

  grp_count_enc u_grp_count_enc (
    .data_i(data_i), .row_cnt_o(row_cnt_o), .row_par_o(row_par_o),
    .col_cnt_o(col_cnt_o), .col_par_o(col_par_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] d);
    @(posedge clk);
    data_i = d;
    @(negedge clk);
  endtask

  task automatic check_model(input string tag);
    int bad_rc = 0, bad_rp = 0, bad_cc = 0, bad_cp = 0;
    for (int r = 0; r < ROWS; r++)
      for (int m = 0; m < SYM_W; m++) begin
        int c = 0;
        for (int k = 0; k < SLICE_N; k++) c += int'(data_i[r*WORD_W + k*SYM_W + m]);
        if (int'(row_cnt_o[(r*SYM_W+m)*RC_W +: RC_W]) != c) bad_rc++;
        if (row_par_o[r*SYM_W+m] != c[0]) bad_rp++;
      end
    for (int j = 0; j < WORD_W; j++) begin
      int c = 0;
      for (int r = 0; r < ROWS; r++) c += int'(data_i[r*WORD_W + j]);
      if (int'(col_cnt_o[j*CC_W +: CC_W]) != c) bad_cc++;
      if (col_par_o[j] != c[0]) bad_cp++;
    end
    check({"R1 R2 slice count mismatches ", tag}, bad_rc, 0);
    check({"R4 slice parity mismatches ", tag}, bad_rp, 0);
    check({"R3 column count mismatches ", tag}, bad_cc, 0);
    check({"R5 column parity mismatches ", tag}, bad_cp, 0);
  endtask

  function automatic int row_total();
    int s = 0;
    for (int i = 0; i < 16; i++) s += int'(row_cnt_o[i*RC_W +: RC_W]);
    return s;
  endfunction

  function automatic int col_total();
    int s = 0;
    for (int j = 0; j < 32; j++) s += int'(col_cnt_o[j*CC_W +: CC_W]);
    return s;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int v = 0; v < N_VEC; v++) begin
      apply(STIM[v]);
      check_model($sformatf("table %0d", v));
      check($sformatf("R9 slice total table %0d", v), row_total(), ONES[v]);
      check($sformatf("R9 column total table %0d", v), col_total(), ONES[v]);
    end

    // R6 all-zero group
    apply('0);
    check("R6 slice counts", int'(row_cnt_o != '0), 0);
    check("R6 column counts", int'(col_cnt_o != '0), 0);
    check("R6 parity", int'({row_par_o, col_par_o} != '0), 0);

    // R7 all-ones group
    apply({128{1'b1}});
    for (int i = 0; i < 16; i++) check("R7 slice count", int'(row_cnt_o[i*RC_W +: RC_W]), 8);
    for (int j = 0; j < 32; j++) check("R7 column count", int'(col_cnt_o[j*CC_W +: CC_W]), 4);
    check("R7 parity", int'({row_par_o, col_par_o} != '0), 0);

    // R1 top bit of word 2 lands in slice 3 of word 2 and column 31
    apply({32'h0, 32'h80000000, 64'h0});
    check("R1 slice field 11", int'(row_cnt_o[11*RC_W +: RC_W]), 1);
    check("R1 column field 31", int'(col_cnt_o[31*CC_W +: CC_W]), 1);
    check("R1 row parity vector", int'(row_par_o), 16'h0800);

    // R8 outputs follow input with no clock edge
    @(negedge clk);
    data_i = {4{32'h0000000F}};
    #1;
    check("R8 column 0 count without edge", int'(col_cnt_o[2:0]), 4);
    check("R8 slice 0 word 0 without edge", int'(row_cnt_o[3:0]), 1);

    for (int n = 0; n < 150; n++) begin
      apply({$urandom, $urandom, $urandom, $urandom});
      check_model($sformatf("random %0d", n));
      check("R9 totals equal", row_total(), col_total());
    end

    finish_run();
  end
endmodule